// File: doc/BRIEF.md
# Address-Space-Tagged Two-Thread Translation Buffer

This block is a small fully associative translation cache shared by the two hardware threads of one core. Each thread owns a translation base register. The low 12 bits of that register name the address space the thread is running in. Every cached translation records the address-space tag it was filled under. A thread therefore only ever hits on translations that belong to its current address space, even when the other thread runs a different address space at the same moment.

The core writes a thread's base register, looks up a virtual page number for a given thread, fills a missing translation, and invalidates translations either by tag or all at once. Changing a base register never flushes anything. Translations of an address space that was switched away survive and hit again when the thread switches back.

A build parameter picks the allocation policy. In the split policy, each thread owns a fixed half of the entries. In the shared policy, both threads compete for every entry and only the tag separates them.

Top module: `shared_tlb`

## Requirements
- R1: After reset no lookup hits, and both base registers read as tag 0. With the shared policy, a translation filled by thread 0 right after reset therefore hits for thread 1 too.
- R2: A lookup hits only when a valid entry holds the requested virtual page number and the tag equal to bits [11:0] of the requesting thread's base register. The hit flag and the physical page number are valid in the same cycle as the request.
- R3: The two base registers are independent and may hold different tags at the same time. Bits above [11:0] have no effect on matching.
- R4: Writing a base register invalidates nothing. A translation filled under a tag hits again once that tag is written back.
- R5: Split policy (SPLIT=1): thread 0 fills and hits only in entries 0 to N/2-1, and thread 1 only in entries N/2 to N-1. Thread 1 never hits on thread 0's entries, even when the tags are equal.
- R6: Shared policy (SPLIT=0): either thread may fill any entry, and either thread hits on an entry whose page and tag match.
- R7: A fill takes the lowest-numbered invalid entry in its allowed range. When that range is full, the fill replaces the entry chosen by a round-robin pointer: one pointer per half in the split policy, and one global pointer in the shared policy. Each pointer starts at the lowest entry of its range and advances only when it is used.
- R8: A fill whose page and tag already match a valid entry in its allowed range overwrites that entry and evicts nothing else.
- R9: An invalidate-by-tag request clears, in one cycle, every valid entry whose stored tag equals the given tag. Entries with other tags are left alone.
- R10: An invalidate-all request clears every entry in one cycle.
- R11: When an invalidate request (by tag or all) and a fill arrive in the same cycle, the invalidate is performed and the fill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptb_we | input | 1 | Base register write strobe |
| ptb_tid | input | 1 | Thread whose base register is written |
| ptb_wdata | input | 32 | New base register value; bits [11:0] are the tag |
| lk_tid | input | 1 | Requesting thread for a lookup |
| lk_vpn | input | 20 | Virtual page number to look up |
| lk_hit | output | 1 | Lookup hit, combinational |
| lk_ppn | output | 20 | Physical page number of the hit, combinational |
| fill_valid | input | 1 | Fill request |
| fill_tid | input | 1 | Thread issuing the fill; its current tag is stored |
| fill_vpn | input | 20 | Virtual page number to fill |
| fill_ppn | input | 20 | Physical page number to fill |
| inv_tag_req | input | 1 | Invalidate entries carrying inv_tag |
| inv_tag | input | 12 | Tag to invalidate |
| inv_all_req | input | 1 | Invalidate every entry |

## Verification
Two functions can land in the same cycle: a fill and an invalidate, either by tag or all. The bench raises fill_valid together with inv_tag_req, first for the tag the fill would carry and then for an unrelated tag, and also together with inv_all_req. A lookup on the filled page afterwards must miss every time, which shows the fill was dropped. A plain fill of the same page afterwards must hit. The bound checker also requires that the number of valid entries never grows in a cycle with an invalidate by tag.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Whether entry idx belongs to the range a thread may use.
  function automatic bit in_zone(input int unsigned idx, input int unsigned n,
                                 input bit split, input logic tid);
    return !split || ((idx >= n / 2) == tid);
  endfunction

  // Number of entries one replacement pointer walks over.
  function automatic int unsigned zone_span(input int unsigned n, input bit split);
    return split ? n / 2 : n;
  endfunction

  // First entry of a thread's range.
  function automatic int unsigned zone_base(input int unsigned n, input bit split,
                                            input logic tid);
    return (split && tid) ? n / 2 : 0;
  endfunction

  // Round-robin step with wrap at the range size.
  function automatic int unsigned rr_step(input int unsigned cur, input int unsigned span);
    return (cur + 1 >= span) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int TAG_W = 12
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0]            allow,
  input  logic [N-1:0][VPN_W-1:0] vpn_arr,
  input  logic [N-1:0][TAG_W-1:0] tag_arr,
  input  logic [VPN_W-1:0]        key_vpn,
  input  logic [TAG_W-1:0]        key_tag,
  output logic [N-1:0]            match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = valid[i] && allow[i] &&
                      (vpn_arr[i] == key_vpn) && (tag_arr[i] == key_tag);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     allow,
  input  logic [N-1:0]     dup,
  input  logic [IDX_W-1:0] rr_idx,
  output logic [IDX_W-1:0] pick,
  output logic             take_rr
);
  logic found;
  always_comb begin
    pick    = '0;
    take_rr = 1'b0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found && dup[i]) begin
        pick  = IDX_W'(i);
        found = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (!found && allow[i] && !valid[i]) begin
        pick  = IDX_W'(i);
        found = 1'b1;
      end
    end
    if (!found) begin
      pick    = rr_idx;
      take_rr = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_rr.sv
module tlb_rr import tlb_pkg::*; #(
  parameter int N     = 16,
  parameter int IDX_W = 4,
  parameter bit SPLIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             tid,
  output logic [IDX_W-1:0] rr_idx
);
  localparam int unsigned SPAN = zone_span(N, SPLIT);
  logic [IDX_W-1:0] ctr_q [2];
  logic             zone;

  assign zone   = SPLIT ? tid : 1'b0;
  assign rr_idx = IDX_W'(zone_base(N, SPLIT, zone)) + ctr_q[zone];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr_q[0] <= '0;
      ctr_q[1] <= '0;
    end else if (adv) begin
      ctr_q[zone] <= IDX_W'(rr_step(int'(ctr_q[zone]), SPAN));
    end
  end
endmodule

// File: rtl/shared_tlb.sv
module shared_tlb import tlb_pkg::*; #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int PTB_W = 32,
  parameter int TAG_W = 12,
  parameter bit SPLIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptb_we,
  input  logic             ptb_tid,
  input  logic [PTB_W-1:0] ptb_wdata,
  input  logic             lk_tid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_valid,
  input  logic             fill_tid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             inv_tag_req,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic             inv_all_req
);
  localparam int IDX_W = $clog2(N);

  logic [PTB_W-1:0]            ptb_q [2];
  logic [N-1:0]                valid_q;
  logic [N-1:0][TAG_W-1:0]     tag_q;
  logic [N-1:0][VPN_W-1:0]     vpn_q;
  logic [N-1:0][PPN_W-1:0]     ppn_q;

  // Named internal events, used by the bound checker.
  logic [TAG_W-1:0] lk_tag, fill_tag;
  logic [N-1:0]     lk_allow, fill_allow, lk_match, fill_dup;
  logic             inv_any, fill_fire, take_rr;
  logic [IDX_W-1:0] rr_idx, victim;
  logic             ptb_hi_unused;

  assign lk_tag        = ptb_q[lk_tid][TAG_W-1:0];
  assign fill_tag      = ptb_q[fill_tid][TAG_W-1:0];
  assign ptb_hi_unused = ^{ptb_q[0][PTB_W-1:TAG_W], ptb_q[1][PTB_W-1:TAG_W]};
  assign inv_any       = inv_tag_req || inv_all_req;
  assign fill_fire     = fill_valid && !inv_any;

  for (genvar i = 0; i < N; i++) begin : g_zone
    assign lk_allow[i]   = in_zone(i, N, SPLIT, lk_tid);
    assign fill_allow[i] = in_zone(i, N, SPLIT, fill_tid);
  end

  tlb_cam #(.N(N), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_lk_cam (
    .valid(valid_q), .allow(lk_allow), .vpn_arr(vpn_q), .tag_arr(tag_q),
    .key_vpn(lk_vpn), .key_tag(lk_tag), .match(lk_match)
  );

  tlb_cam #(.N(N), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_fill_cam (
    .valid(valid_q), .allow(fill_allow), .vpn_arr(vpn_q), .tag_arr(tag_q),
    .key_vpn(fill_vpn), .key_tag(fill_tag), .match(fill_dup)
  );

  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i]) lk_ppn = lk_ppn | ppn_q[i];
    end
  end
  assign lk_hit = |lk_match;

  tlb_rr #(.N(N), .IDX_W(IDX_W), .SPLIT(SPLIT)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(fill_fire && take_rr),
    .tid(fill_tid), .rr_idx(rr_idx)
  );

  tlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
    .valid(valid_q), .allow(fill_allow), .dup(fill_dup),
    .rr_idx(rr_idx), .pick(victim), .take_rr(take_rr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      ptb_q[0] <= '0;
      ptb_q[1] <= '0;
    end else begin
      if (ptb_we) ptb_q[ptb_tid] <= ptb_wdata;
      if (inv_all_req) begin
        valid_q <= '0;
      end else if (inv_tag_req) begin
        for (int i = 0; i < N; i++) begin
          if (tag_q[i] == inv_tag) valid_q[i] <= 1'b0;
        end
      end else if (fill_valid) begin
        valid_q[victim] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_fire) begin
      tag_q[victim] <= fill_tag;
      vpn_q[victim] <= fill_vpn;
      ppn_q[victim] <= fill_ppn;
    end
  end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int N     = 16,
  parameter bit SPLIT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] valid_q,
  input logic [N-1:0] lk_match,
  input logic         lk_tid,
  input logic         ptb_we,
  input logic         fill_valid,
  input logic         inv_tag_req,
  input logic         inv_all_req
);
  logic [N-1:0] hi_mask;
  always_comb begin
    for (int i = 0; i < N; i++) hi_mask[i] = (i >= N / 2);
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> valid_q == '0);

  assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  assert_no_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptb_we && !fill_valid && !inv_tag_req && !inv_all_req) |=> valid_q == $past(valid_q));

  assert_zone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (SPLIT && !lk_tid) |-> (lk_match & hi_mask) == '0);

  assert_fill_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> $countones(valid_q) <= $countones($past(valid_q)) + 1);

  assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all_req |=> valid_q == '0);

  assert_inv_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_tag_req |=> $countones(valid_q) <= $countones($past(valid_q)));
endmodule

bind shared_tlb tlb_checker #(.N(N), .SPLIT(SPLIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_q(valid_q), .lk_match(lk_match),
  .lk_tid(lk_tid), .ptb_we(ptb_we), .fill_valid(fill_valid),
  .inv_tag_req(inv_tag_req), .inv_all_req(inv_all_req)
);

// File: tb/shared_tlb_tb.sv
module shared_tlb_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        ptb_we = 1'b0, ptb_tid = 1'b0;
  logic [31:0] ptb_wdata = '0;
  logic        lk_tid = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic        fill_valid = 1'b0, fill_tid = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic        inv_tag_req = 1'b0, inv_all_req = 1'b0;
  logic [11:0] inv_tag = '0;
  logic        hit_p, hit_s;
  logic [19:0] ppn_p, ppn_s;
  int          n_tot = 0, n_fail = 0;

  shared_tlb #(.SPLIT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ptb_we(ptb_we), .ptb_tid(ptb_tid), .ptb_wdata(ptb_wdata),
    .lk_tid(lk_tid), .lk_vpn(lk_vpn), .lk_hit(hit_p), .lk_ppn(ppn_p),
    .fill_valid(fill_valid), .fill_tid(fill_tid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .inv_tag_req(inv_tag_req), .inv_tag(inv_tag), .inv_all_req(inv_all_req));

  shared_tlb #(.SPLIT(1'b0)) dut_shared (
    .clk(clk), .rst_n(rst_n), .ptb_we(ptb_we), .ptb_tid(ptb_tid), .ptb_wdata(ptb_wdata),
    .lk_tid(lk_tid), .lk_vpn(lk_vpn), .lk_hit(hit_s), .lk_ppn(ppn_s),
    .fill_valid(fill_valid), .fill_tid(fill_tid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .inv_tag_req(inv_tag_req), .inv_tag(inv_tag), .inv_all_req(inv_all_req));

  // Vector: op[79:78] tid[77] vpn[76:57] data[56:25] exp_hit[24] exp_ppn[23:4] req[3:0]
  // op 0 = lookup check on the split instance, 1 = fill, 2 = base write, 3 = invalidate tag
  localparam int NV = 17;
  localparam logic [79:0] VEC [NV] = '{
    {2'd0, 1'b0, 20'h00010, 32'h0,        1'b0, 20'h0,     4'd1},  // R1 empty
    {2'd2, 1'b0, 20'h0,     32'h0000_1005, 1'b0, 20'h0,    4'd3},  // R3 t0 tag 5
    {2'd2, 1'b1, 20'h0,     32'hFFFF_F007, 1'b0, 20'h0,    4'd3},  // R3 t1 tag 7
    {2'd1, 1'b0, 20'h00010, 32'h000A_AAAA, 1'b0, 20'h0,    4'd2},
    {2'd0, 1'b0, 20'h00010, 32'h0,        1'b1, 20'hAAAAA, 4'd2},  // R2 hit
    {2'd0, 1'b0, 20'h00011, 32'h0,        1'b0, 20'h0,     4'd2},  // R2 page differs
    {2'd0, 1'b1, 20'h00010, 32'h0,        1'b0, 20'h0,     4'd3},  // R3 tag differs
    {2'd1, 1'b1, 20'h00010, 32'h000B_BBBB, 1'b0, 20'h0,    4'd3},
    {2'd0, 1'b1, 20'h00010, 32'h0,        1'b1, 20'hBBBBB, 4'd3},  // R3 both live
    {2'd0, 1'b0, 20'h00010, 32'h0,        1'b1, 20'hAAAAA, 4'd3},
    {2'd2, 1'b0, 20'h0,     32'h0000_2009, 1'b0, 20'h0,    4'd4},  // R4 switch away
    {2'd0, 1'b0, 20'h00010, 32'h0,        1'b0, 20'h0,     4'd4},
    {2'd2, 1'b0, 20'h0,     32'h0000_7005, 1'b0, 20'h0,    4'd4},  // R4 back, high bits differ
    {2'd0, 1'b0, 20'h00010, 32'h0,        1'b1, 20'hAAAAA, 4'd4},
    {2'd3, 1'b0, 20'h0,     32'h0000_0005, 1'b0, 20'h0,    4'd9},  // R9 drop tag 5
    {2'd0, 1'b0, 20'h00010, 32'h0,        1'b0, 20'h0,     4'd9},
    {2'd0, 1'b1, 20'h00010, 32'h0,        1'b1, 20'hBBBBB, 4'd9}
  };

  task automatic chk(input bit shr, input logic t, input logic [19:0] v,
                     input bit eh, input logic [19:0] ep, input int req);
    logic h;
    logic [19:0] p;
    @(negedge clk);
    lk_tid = t;
    lk_vpn = v;
    #1;
    h = shr ? hit_s : hit_p;
    p = shr ? ppn_s : ppn_p;
    n_tot++;
    if (h !== eh || (eh && p !== ep)) begin
      n_fail++;
      $display("FAIL R%0d %s t%0d vpn %h: hit %b ppn %h, expected hit %b ppn %h",
               req, shr ? "shared" : "split", t, v, h, p, eh, ep);
    end
  endtask

  task automatic fill(input logic t, input logic [19:0] v, input logic [19:0] p);
    @(negedge clk);
    fill_valid = 1'b1; fill_tid = t; fill_vpn = v; fill_ppn = p;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic wr_ptb(input logic t, input logic [31:0] d);
    @(negedge clk);
    ptb_we = 1'b1; ptb_tid = t; ptb_wdata = d;
    @(negedge clk);
    ptb_we = 1'b0;
  endtask

  task automatic inv(input bit all, input logic [11:0] g);
    @(negedge clk);
    inv_all_req = all; inv_tag_req = !all; inv_tag = g;
    @(negedge clk);
    inv_all_req = 1'b0; inv_tag_req = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_tot++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state on both policies and both threads
    chk(1'b0, 1'b0, 20'h0, 1'b0, 20'h0, 1);
    chk(1'b1, 1'b1, 20'h0, 1'b0, 20'h0, 1);

    for (int k = 0; k < NV; k++) begin
      logic [79:0] v;
      v = VEC[k];
      case (v[79:78])
        2'd0: chk(1'b0, v[77], v[76:57], v[24], v[23:4], int'(v[3:0]));
        2'd1: fill(v[77], v[76:57], v[44:25]);
        2'd2: wr_ptb(v[77], v[56:25]);
        default: inv(1'b0, v[36:25]);
      endcase
    end

    // R1 / R5 / R6: both base registers are zero after reset
    do_reset();
    chk(1'b0, 1'b0, 20'h00010, 1'b0, 20'h0, 1);
    fill(1'b0, 20'h00055, 20'h00001);
    chk(1'b1, 1'b1, 20'h00055, 1'b1, 20'h00001, 6);  // R6 other thread hits
    chk(1'b0, 1'b1, 20'h00055, 1'b0, 20'h0, 5);      // R5 other half invisible
    chk(1'b0, 1'b0, 20'h00055, 1'b1, 20'h00001, 5);

    // R7 invalid-first then round robin
    do_reset();
    for (int i = 0; i < 16; i++) fill(1'b0, 20'h00100 + 20'(i), 20'h80100 + 20'(i));
    chk(1'b0, 1'b0, 20'h00107, 1'b0, 20'h0, 7);      // split half cycled once: 0x108..0x10F
    chk(1'b0, 1'b0, 20'h00108, 1'b1, 20'h80108, 7);
    chk(1'b1, 1'b0, 20'h00100, 1'b1, 20'h80100, 7);  // shared: all 16 live
    chk(1'b1, 1'b0, 20'h0010F, 1'b1, 20'h8010F, 7);
    fill(1'b0, 20'h00110, 20'h80110);
    chk(1'b0, 1'b0, 20'h00108, 1'b0, 20'h0, 7);      // split pointer wrapped to entry 0
    chk(1'b0, 1'b0, 20'h00109, 1'b1, 20'h80109, 7);
    chk(1'b0, 1'b0, 20'h00110, 1'b1, 20'h80110, 7);
    chk(1'b1, 1'b0, 20'h00100, 1'b0, 20'h0, 7);      // shared evicts entry 0
    chk(1'b1, 1'b0, 20'h00101, 1'b1, 20'h80101, 7);
    chk(1'b1, 1'b0, 20'h00110, 1'b1, 20'h80110, 6);

    // R8 refill of a cached page overwrites in place
    fill(1'b0, 20'h00109, 20'h12345);
    chk(1'b0, 1'b0, 20'h00109, 1'b1, 20'h12345, 8);
    chk(1'b1, 1'b0, 20'h00109, 1'b1, 20'h12345, 8);
    chk(1'b0, 1'b0, 20'h0010A, 1'b1, 20'h8010A, 8);
    chk(1'b0, 1'b0, 20'h00110, 1'b1, 20'h80110, 8);
    chk(1'b1, 1'b0, 20'h00101, 1'b1, 20'h80101, 8);

    // R10 invalidate all
    inv(1'b1, 12'h0);
    chk(1'b0, 1'b0, 20'h00110, 1'b0, 20'h0, 10);
    chk(1'b1, 1'b0, 20'h00101, 1'b0, 20'h0, 10);

    // R11 invalidate beats a fill in the same cycle
    @(negedge clk);
    fill_valid = 1'b1; fill_tid = 1'b0; fill_vpn = 20'h00200; fill_ppn = 20'h00222;
    inv_tag_req = 1'b1; inv_tag = 12'h000;
    @(negedge clk);
    inv_tag = 12'h3FF;
    @(negedge clk);
    inv_tag_req = 1'b0; inv_all_req = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0; inv_all_req = 1'b0;
    chk(1'b0, 1'b0, 20'h00200, 1'b0, 20'h0, 11);
    chk(1'b1, 1'b0, 20'h00200, 1'b0, 20'h0, 11);
    fill(1'b0, 20'h00200, 20'h00222);
    chk(1'b0, 1'b0, 20'h00200, 1'b1, 20'h00222, 11);
    chk(1'b1, 1'b1, 20'h00200, 1'b1, 20'h00222, 11);

    finish_run();
  end
endmodule